// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block brings up a programmable-logic target that takes its configuration over a slave-serial link. A start pulse begins a load. The block raises the target's power enable and waits a settle period. It then pulses the active-low program line for a fixed hold time and waits, within a bounded number of polls, for the target to report that it is ready. Configuration bytes arrive on a valid/ready stream and leave on the data pin, most significant bit first. The block generates a serial clock to carry them. After the given number of bytes it keeps clocking until the target raises its done line, or gives up after a bounded number of pulses.

The serial clock half-period, the settle and hold delays and both wait limits are parameters counted in system-clock cycles. The ready and done inputs come from another clock domain, so each passes through a two-flop synchroniser before it is used. When a load succeeds, busy drops and a success flag rises. When a wait times out, busy stays high and an error flag rises. In either case a new start pulse may begin another attempt.

Top module: `cfg_serial_loader`

## Requirements
- R1: On an accepted start, `pwr_en_o` rises in the same cycle as `busy_o` and stays high from then on. `prog_n_o` stays high for exactly SETTLE_CYC cycles after that before it falls.
- R2: After reset, `pwr_en_o`, `cclk_o`, `din_o`, `busy_o`, `ok_o`, `err_o` and `byte_ready_o` are 0 and `prog_n_o` is 1.
- R3: `prog_n_o` is held low for exactly HOLD_CYC cycles and then returns high.
- R4: After `prog_n_o` returns high, the block polls the synchronised ready input once per cycle for at most INIT_POLLS cycles. If the ready input never rises, `err_o` becomes 1 after exactly INIT_POLLS cycles, `busy_o` stays 1 and `cclk_o` makes no pulse.
- R5: Each byte leaves MSB first. `din_o` changes only while `cclk_o` is low, both before and after the change, and holds steady while `cclk_o` is high. The target samples on the rising edge of `cclk_o`. Each high and each low phase of `cclk_o` lasts HALF_DIV cycles.
- R6: Exactly `len_i` bytes, captured at start, are taken from the stream and shifted out, each taken when `byte_valid_i` and `byte_ready_o` are both 1. A length of 0 sends no data bits.
- R7: A 1 on `byte_err_i` while `byte_ready_o` is 1 ends the data phase at once, with no further byte taken. The block moves on to the trailing-clock phase.
- R8: After the data phase, `cclk_o` keeps pulsing until the synchronised done input is seen high at the start of a low phase. A target that raises done right after rising edge N produces exactly N rising edges in total.
- R9: If done does not rise within DONE_PULSES trailing pulses, `err_o` becomes 1, `busy_o` stays 1 and `cclk_o` stops low.
- R10: On success, `busy_o` falls to 0, `ok_o` becomes 1 and `err_o` stays 0. `ok_o` and `err_o` are never 1 together.
- R11: While `busy_o` is 1 and `err_o` is 0, a start pulse has no effect. After success or failure, a start pulse begins a new full sequence and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, one cycle |
| len_i | input | LEN_W | Number of configuration bytes, captured at start |
| byte_data_i | input | BYTE_W | Stream byte |
| byte_valid_i | input | 1 | Stream byte is valid |
| byte_err_i | input | 1 | Stream failure; ends the data phase |
| byte_ready_o | output | 1 | Loader accepts a byte this cycle |
| cfg_init_i | input | 1 | Target ready (high = ready to receive), asynchronous |
| cfg_done_i | input | 1 | Target configuration complete, asynchronous |
| pwr_en_o | output | 1 | Target power enable |
| prog_n_o | output | 1 | Active-low program pulse |
| cclk_o | output | 1 | Generated configuration clock |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress, or a failed load |
| ok_o | output | 1 | Last load succeeded |
| err_o | output | 1 | Last load timed out |

## Verification
The bench builds the block with HALF_DIV=3, SETTLE_CYC=5, HOLD_CYC=4, INIT_POLLS=30, DONE_PULSES=12 and LEN_W=8. With these short limits, both timeouts can be reached and counted cycle by cycle: the 30-cycle ready wait and the 12-pulse done wait. The settle and hold windows can be measured exactly. An odd clock divider makes an error in the high-phase length visible. A behavioural target model lowers its ready line while the program line is low, raises done after a chosen count of rising clock edges, and captures data bits on each rising edge. With this model the bench can compare the bytes received, the total edge count and the outcome flags against values worked out from the requirements alone.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   typedef enum logic [3:0] {
      LD_IDLE,
      LD_SETTLE,
      LD_PROG,
      LD_AWAIT_RDY,
      LD_FETCH,
      LD_SHIFT,
      LD_TRAIL,
      LD_PASS,
      LD_FAIL
   } ld_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
   parameter int HALF_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic cclk_o,
   output logic lo_first_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;
   logic          hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         hi_q  <= ~hi_q;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign cclk_o     = hi_q;
   assign lo_first_o = run_i && !hi_q && (cnt_q == '0);
   assign rise_o     = run_i && !hi_q && (cnt_q == LAST);
   assign fall_o     = run_i &&  hi_q && (cnt_q == LAST);

   // R5: the clock may only leave its low state while running
   assert_cclk_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_q) |-> $past(run_i));

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              present_i,
   input  logic              advance_i,
   output logic              din_o,
   output logic              last_bit_o
);

   localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   logic [BYTE_W-1:0] shreg_q;
   logic [BW-1:0]     left_q;
   logic              din_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
         din_q   <= 1'b0;
      end else begin
         if (load_i) begin
            shreg_q <= data_i;
            left_q  <= BW'(BYTE_W - 1);
         end else if (advance_i) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            left_q  <= left_q - BW'(1);
         end
         if (present_i) din_q <= shreg_q[BYTE_W-1];
      end
   end

   assign din_o      = din_q;
   assign last_bit_o = (left_q == '0);

   // R6: a new byte is never loaded while a bit is being presented
   assert_no_load_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !present_i && !advance_i);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_loader_pkg::*;
#(
   parameter int HALF_DIV    = 6,
   parameter int SETTLE_CYC  = 1000,
   parameter int HOLD_CYC    = 1000,
   parameter int INIT_POLLS  = 100000,
   parameter int DONE_PULSES = 100000,
   parameter int LEN_W       = 24,
   parameter int BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [BYTE_W-1:0] byte_data_i,
   input  logic              byte_valid_i,
   input  logic              byte_err_i,
   output logic              byte_ready_o,
   input  logic              cfg_init_i,
   input  logic              cfg_done_i,
   output logic              pwr_en_o,
   output logic              prog_n_o,
   output logic              cclk_o,
   output logic              din_o,
   output logic              busy_o,
   output logic              ok_o,
   output logic              err_o
);

   localparam int MAXD = max3(SETTLE_CYC, HOLD_CYC, INIT_POLLS);
   localparam int DW   = $clog2(MAXD + 1);
   localparam int PW   = $clog2(DONE_PULSES + 1);

   if (HALF_DIV < 2) begin : g_bad_div
      $error("cfg_serial_loader: HALF_DIV must be at least 2");
   end
   if (SETTLE_CYC < 1 || HOLD_CYC < 1 || INIT_POLLS < 1 || DONE_PULSES < 1) begin : g_bad_dly
      $error("cfg_serial_loader: delays and limits must be at least 1");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("cfg_serial_loader: BYTE_W must be at least 2");
   end

   ld_state_e        state_q;
   logic [DW-1:0]    dly_q;
   logic [PW-1:0]    pulses_q;
   logic [LEN_W-1:0] left_q;
   logic             pwr_q;
   logic             prog_n_q;

   logic init_s, done_s;
   logic run, lo_first, rise, fall;
   logic load, last_bit;

   cfg_sync #(.WIDTH(2), .STAGES(2)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({cfg_done_i, cfg_init_i}),
      .sync_o  ({done_s, init_s})
   );

   assign run = (state_q == LD_SHIFT) || (state_q == LD_TRAIL);

   cfg_cclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .cclk_o     (cclk_o),
      .lo_first_o (lo_first),
      .rise_o     (rise),
      .fall_o     (fall)
   );

   assign byte_ready_o = (state_q == LD_FETCH);
   assign load         = byte_ready_o && byte_valid_i && !byte_err_i;

   cfg_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .data_i     (byte_data_i),
      .present_i  ((state_q == LD_SHIFT) && lo_first),
      .advance_i  ((state_q == LD_SHIFT) && fall),
      .din_o      (din_o),
      .last_bit_o (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= LD_IDLE;
         dly_q    <= '0;
         pulses_q <= '0;
         left_q   <= '0;
         pwr_q    <= 1'b0;
         prog_n_q <= 1'b1;
      end else begin
         unique case (state_q)
            LD_IDLE, LD_PASS, LD_FAIL: begin
               if (start_i) begin
                  state_q  <= LD_SETTLE;
                  pwr_q    <= 1'b1;
                  prog_n_q <= 1'b1;
                  dly_q    <= '0;
                  left_q   <= len_i;
               end
            end
            LD_SETTLE: begin
               if (dly_q == DW'(SETTLE_CYC - 1)) begin
                  state_q  <= LD_PROG;
                  prog_n_q <= 1'b0;
                  dly_q    <= '0;
               end else begin
                  dly_q <= dly_q + DW'(1);
               end
            end
            LD_PROG: begin
               if (dly_q == DW'(HOLD_CYC - 1)) begin
                  state_q  <= LD_AWAIT_RDY;
                  prog_n_q <= 1'b1;
                  dly_q    <= '0;
               end else begin
                  dly_q <= dly_q + DW'(1);
               end
            end
            LD_AWAIT_RDY: begin
               if (init_s) begin
                  state_q  <= (left_q == '0) ? LD_TRAIL : LD_FETCH;
                  pulses_q <= '0;
               end else if (dly_q == DW'(INIT_POLLS - 1)) begin
                  state_q <= LD_FAIL;
               end else begin
                  dly_q <= dly_q + DW'(1);
               end
            end
            LD_FETCH: begin
               if (byte_err_i) begin
                  state_q  <= LD_TRAIL;
                  pulses_q <= '0;
               end else if (byte_valid_i) begin
                  state_q <= LD_SHIFT;
               end
            end
            LD_SHIFT: begin
               if (fall && last_bit) begin
                  left_q <= left_q - LEN_W'(1);
                  if (left_q == LEN_W'(1)) begin
                     state_q  <= LD_TRAIL;
                     pulses_q <= '0;
                  end else begin
                     state_q <= LD_FETCH;
                  end
               end
            end
            LD_TRAIL: begin
               if (lo_first) begin
                  if (done_s)                              state_q <= LD_PASS;
                  else if (pulses_q == PW'(DONE_PULSES))   state_q <= LD_FAIL;
               end
               if (fall) pulses_q <= pulses_q + PW'(1);
            end
            default: state_q <= LD_IDLE;
         endcase
      end
   end

   assign pwr_en_o = pwr_q;
   assign prog_n_o = prog_n_q;
   assign busy_o   = (state_q != LD_IDLE) && (state_q != LD_PASS);
   assign ok_o     = (state_q == LD_PASS);
   assign err_o    = (state_q == LD_FAIL);

   // R1: the program line is only ever driven low with power already on
   assert_power_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n_o |-> pwr_en_o);

   // R1: once raised, power enable never drops
   assert_power_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en_o) |-> 1'b0);

   // R2: no clock activity while not busy
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !cclk_o);

   // R5: the data pin only moves while the clock is low before and after
   assert_din_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (din_o != $past(din_o)) |-> (!$past(cclk_o) && !cclk_o));

   // R6: no byte is fetched with nothing left to send
   assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready_o |-> (left_q != '0));

   // R9: after a failure the clock rests low
   assert_fail_clock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !cclk_o);

   // R10: the outcome flags are exclusive
   assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_o && err_o));

   // R11: a busy, non-failed loader does not restart on start
   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && !$past(err_o) && busy_o) |-> ($past(pwr_en_o) == pwr_en_o) && !($rose(prog_n_o) && $past(state_q) == LD_SETTLE));

endmodule

// File: tb/cfg_serial_loader_tb.sv
`timescale 1ns/1ps
module cfg_serial_loader_tb;

   localparam int HALF_DIV    = 3;
   localparam int SETTLE_CYC  = 5;
   localparam int HOLD_CYC    = 4;
   localparam int INIT_POLLS  = 30;
   localparam int DONE_PULSES = 12;
   localparam int LEN_W       = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [LEN_W-1:0] len_i = '0;
   logic [7:0] byte_data_i = '0;
   logic byte_valid_i = 1'b0;
   logic byte_err_i = 1'b0;
   logic byte_ready_o;
   logic cfg_init_i = 1'b0;
   logic cfg_done_i = 1'b0;
   logic pwr_en_o, prog_n_o, cclk_o, din_o, busy_o, ok_o, err_o;

   always #2 clk = ~clk;

   cfg_serial_loader #(
      .HALF_DIV(HALF_DIV), .SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC),
      .INIT_POLLS(INIT_POLLS), .DONE_PULSES(DONE_PULSES), .LEN_W(LEN_W), .BYTE_W(8)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_err_i(byte_err_i),
      .byte_ready_o(byte_ready_o), .cfg_init_i(cfg_init_i), .cfg_done_i(cfg_done_i),
      .pwr_en_o(pwr_en_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
      .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o)
   );

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // stream source and target model state
   logic [7:0] byte_mem [16];
   int  src_idx = 0;
   bit  src_active = 0;
   bit  src_gap = 0;
   bit  gap_ph = 0;
   bit  xfer_pend = 0;
   int  err_at = -1;
   int  init_dly = -1;
   int  init_cnt = 0;
   int  done_thresh = -1;
   int  rise_cnt = 0;
   logic [7:0] cap [16];
   logic din_at_rise = 1'b0;
   int  din_glitch = 0;
   int  hi_run = 0;
   int  last_hi = 0;
   int  prog_falls = 0;
   logic prev_prog = 1'b1;
   int  cycles = 0;

   always @(negedge clk) begin
      if (xfer_pend) src_idx++;
      gap_ph = ~gap_ph;
      byte_valid_i = src_active && (!src_gap || gap_ph) && (src_idx != err_at) && (src_idx < 16);
      byte_err_i   = src_active && byte_ready_o && (src_idx == err_at);
      byte_data_i  = byte_mem[src_idx % 16];
      xfer_pend    = byte_ready_o && byte_valid_i;

      if (!prog_n_o) begin
         cfg_init_i = 1'b0;
         cfg_done_i = 1'b0;
         init_cnt   = 0;
      end else begin
         if (init_dly >= 0 && init_cnt >= init_dly) cfg_init_i = 1'b1;
         init_cnt++;
         if (done_thresh >= 0 && rise_cnt >= done_thresh) cfg_done_i = 1'b1;
      end

      if (cclk_o) begin
         hi_run++;
         if (din_o !== din_at_rise) din_glitch++;
      end else if (hi_run != 0) begin
         last_hi = hi_run;
         hi_run = 0;
      end
      if (prev_prog && !prog_n_o) prog_falls++;
      prev_prog = prog_n_o;
   end

   always @(posedge cclk_o) begin
      if (rise_cnt < 128) cap[rise_cnt / 8][7 - (rise_cnt % 8)] = din_o;
      din_at_rise = din_o;
      rise_cnt++;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // one load; returns measured settle, hold and pre-data poll counts
   task automatic run_load(input int len, input int idly, input int done_extra, input int data_bytes,
                           input bit gap, input int eat, input int restart_at,
                           output int settle, output int hold, output int polls);
      rise_cnt = 0; src_idx = 0; src_gap = gap; err_at = eat; prog_falls = 0;
      init_dly = idly;
      done_thresh = (done_extra < 0) ? -1 : 8 * data_bytes + done_extra;
      for (int i = 0; i < 16; i++) cap[i] = 8'h00;
      @(negedge clk);
      len_i = LEN_W'(len);
      src_active = 1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      settle = 0;
      while (prog_n_o === 1'b1 && settle < 1000) begin settle++; @(negedge clk); end
      hold = 0;
      while (prog_n_o === 1'b0 && hold < 1000) begin hold++; @(negedge clk); end
      polls = 0;
      while (!err_o && !byte_ready_o && !cclk_o && !ok_o && polls < 1000) begin polls++; @(negedge clk); end
      for (int t = 0; t < 5000 && !ok_o && !err_o; t++) begin
         if (restart_at >= 0 && rise_cnt == restart_at && !start_i) begin
            start_i = 1'b1;
            restart_at = -1;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      src_active = 0;
      @(negedge clk);
   endtask

   task automatic check_bytes(input int n, input string req);
      for (int i = 0; i < n; i++)
         chk(cap[i] == byte_mem[i], req, $sformatf("byte %0d", i), cap[i], byte_mem[i]);
   endtask

   task automatic t_reset();
      chk(pwr_en_o == 0 && cclk_o == 0 && din_o == 0, "R2", "pwr/cclk/din after reset", {pwr_en_o, cclk_o, din_o}, 0);
      chk(prog_n_o == 1, "R2", "prog_n after reset", prog_n_o, 1);
      chk(busy_o == 0 && ok_o == 0 && err_o == 0 && byte_ready_o == 0, "R2", "flags after reset",
          {busy_o, ok_o, err_o, byte_ready_o}, 0);
   endtask

   task automatic t_basic();
      int s, h, p;
      run_load(4, 6, 3, 4, 0, -1, -1, s, h, p);
      chk(s == SETTLE_CYC, "R1", "settle cycles", s, SETTLE_CYC);
      chk(pwr_en_o == 1, "R1", "power stays on", pwr_en_o, 1);
      chk(h == HOLD_CYC, "R3", "program hold cycles", h, HOLD_CYC);
      check_bytes(4, "R5");
      chk(last_hi == HALF_DIV, "R5", "cclk high phase", last_hi, HALF_DIV);
      chk(din_glitch == 0, "R5", "din moved while cclk high", din_glitch, 0);
      chk(rise_cnt == 35, "R8", "rising edges incl trailing", rise_cnt, 35);
      chk(ok_o == 1 && busy_o == 0 && err_o == 0, "R10", "success flags", {ok_o, busy_o, err_o}, 4);
   endtask

   task automatic t_gapped();
      int s, h, p;
      run_load(5, 2, 0, 5, 1, -1, -1, s, h, p);
      check_bytes(5, "R6");
      chk(rise_cnt == 40, "R6", "exactly len bytes of edges", rise_cnt, 40);
      chk(ok_o == 1, "R10", "gapped load ok", ok_o, 1);
   endtask

   task automatic t_zero_len();
      int s, h, p;
      run_load(0, 3, 2, 0, 0, -1, -1, s, h, p);
      chk(rise_cnt == 2, "R6", "zero length sends only trailing", rise_cnt, 2);
      chk(ok_o == 1, "R8", "zero length completes on done", ok_o, 1);
   endtask

   task automatic t_init_timeout();
      int s, h, p;
      run_load(3, -1, 0, 3, 0, -1, -1, s, h, p);
      chk(p == INIT_POLLS, "R4", "ready polls before error", p, INIT_POLLS);
      chk(err_o == 1 && busy_o == 1 && ok_o == 0, "R4", "timeout flags", {err_o, busy_o, ok_o}, 6);
      chk(rise_cnt == 0, "R4", "no cclk pulse on ready timeout", rise_cnt, 0);
   endtask

   task automatic t_restart_after_fail();
      int s, h, p;
      run_load(2, 1, 1, 2, 0, -1, -1, s, h, p);
      chk(s == SETTLE_CYC && h == HOLD_CYC, "R11", "full sequence after failure", s + h, SETTLE_CYC + HOLD_CYC);
      chk(ok_o == 1 && err_o == 0, "R11", "flags cleared on restart", {ok_o, err_o}, 2);
      check_bytes(2, "R11");
   endtask

   task automatic t_stream_err();
      int s, h, p;
      run_load(5, 2, 1, 2, 0, 2, -1, s, h, p);
      chk(rise_cnt == 17, "R7", "edges after stream error", rise_cnt, 17);
      check_bytes(2, "R7");
      chk(ok_o == 1, "R7", "proceeds to done after stream error", ok_o, 1);
   endtask

   task automatic t_done_timeout();
      int s, h, p;
      run_load(2, 2, -1, 2, 0, -1, -1, s, h, p);
      chk(rise_cnt == 16 + DONE_PULSES, "R9", "trailing pulses before error", rise_cnt, 16 + DONE_PULSES);
      chk(err_o == 1 && busy_o == 1, "R9", "done timeout flags", {err_o, busy_o}, 3);
      chk(cclk_o == 0, "R9", "cclk rests low", cclk_o, 0);
   endtask

   task automatic t_start_while_busy();
      int s, h, p;
      run_load(3, 2, 2, 3, 0, -1, 10, s, h, p);
      chk(prog_falls == 1, "R11", "program pulses during one load", prog_falls, 1);
      chk(rise_cnt == 26, "R11", "load unaffected by start", rise_cnt, 26);
      check_bytes(3, "R11");
   endtask

   initial begin
      for (int i = 0; i < 16; i++) byte_mem[i] = 8'((i * 37 + 5) ^ (i << 4));
      byte_mem[0] = 8'hA5;
      byte_mem[1] = 8'h01;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_gapped();
      t_zero_len();
      t_init_timeout();
      t_restart_after_fail();
      t_stream_err();
      t_done_timeout();
      t_start_while_busy();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule